// File: doc/BRIEF.md
# DRAM Command Issue and Pin Gating Stage

This block sits between the command scheduler of a DRAM controller and the memory pins. It accepts one command request per cycle over a ready/valid handshake, registers it onto the chip-select, RAS, CAS, WE, address and bank-address pins, and records which banks of each rank are open. It is configured by a set of static control inputs that a configuration register outside the block drives.

Before a refresh or mode-register load it issues a precharge-all on its own when the target rank still has an open bank, or always when forced. It can hold an empty cycle after every command. In the debug mode it places a debug word on the address pins in the cycle after a command, and it can splice the byte enables of a read into that word. Output enables are gated per pin group: the clock enables, each DIMM's control lines, and the address/bank lines. Address and control pins can be released during idle cycles and in low-power mode.

Commands appear on the pins one clock after the handshake that accepts them. Any command that is held back stalls the upstream interface, and no request is dropped or reordered.

Top module: `dram_cmd_gate`

## Requirements
- R1: With `cfg_b2b_dis` high, a pin cycle that follows a command cycle carries no command, and the held request goes out one cycle later. With it low, accepted commands go out in consecutive cycles.
- R2: With `cfg_dbg_en` high, the cycle after a command shows `dbg_data` on `dram_ma` while all chip selects are high. With it low, an idle cycle shows zero on `dram_ma`.
- R3: With `cfg_rbe_en` high, the debug word that follows a read whose `req_be_vld` was set has its low 4 bits replaced by that read's `req_be`. In every other case the word is `dbg_data` unchanged.
- R4: A refresh (request code 6) or load-mode (code 7) request aimed at a rank that has any bank open is preceded by a precharge-all on that rank: RAS/CAS/WE = 010 with address bit 10 high. If all banks of that rank are closed, no precharge-all is inserted.
- R5: With `cfg_force_pre` high, the precharge-all is inserted before refresh or load-mode even when every bank of the rank is closed.
- R6: `cfg_cke_mask` bit 0 masks CKE0 and bit 1 masks CKE1: `dram_cke_oe[i]` is the inverse of `cfg_cke_mask[i]`. So 00 drives both, 01 masks only CKE0, 10 masks only CKE1, and 11 masks both.
- R7: `cfg_ctl_mask[d]` high clears `dram_ctl_oe[d]`, which covers DIMM d's RAS, CAS, WE and its two chip selects (DIMM0 owns chip selects 1:0, DIMM1 owns 3:2).
- R8: `cfg_addr_mask` high clears `dram_ma_oe`, which covers the address and bank-address pins.
- R9: With `cfg_tri_dis` low, `dram_ma_oe` and `dram_ctl_oe` are low in cycles without a command or debug word, and in every cycle while `lowpower` is high. With `cfg_tri_dis` high they depend only on the masks.
- R10: Request codes are NOP 0, ACT 1, RD 2, WR 3, PRE 4, PREA 5, REF 6, LMR 7. Accepted requests reach the pins in their order of acceptance, one clock after the accepting edge. A held request keeps `req_ready` low until it is taken.
- R11: A command drives the chip select of its rank low (one bit of `dram_cs_n`). It drives RAS/CAS/WE of that rank's DIMM (ranks 0–1 belong to DIMM0, ranks 2–3 to DIMM1) as ACT 011, RD 101, WR 100, PRE 010 with address bit 10 low, REF 001, LMR 000. The other DIMM's lines stay at 111.
- R12: ACT opens the addressed bank, PRE closes it, and PREA closes all banks of its rank. This state alone decides the insertion in R4.
- R13: After reset all chip selects and RAS/CAS/WE lines are high, the address pins are zero, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_cmd | input | 3 | Request code (see R10) |
| req_rank | input | 2 | Target rank |
| req_bank | input | 2 | Target bank |
| req_addr | input | 13 | Row/column/mode address |
| req_be | input | 4 | Byte enables of a read |
| req_be_vld | input | 1 | The read carries byte enables |
| dbg_data | input | 13 | Debug word for the post-command cycle |
| cfg_b2b_dis | input | 1 | Force an empty cycle after each command |
| cfg_dbg_en | input | 1 | Debug word mode |
| cfg_rbe_en | input | 1 | Splice read byte enables into debug word |
| cfg_force_pre | input | 1 | Unconditional precharge-all before REF/LMR |
| cfg_tri_dis | input | 1 | Keep address/control pins driven |
| cfg_cke_mask | input | 2 | Per-bit CKE output mask |
| cfg_ctl_mask | input | 2 | Per-DIMM control output mask |
| cfg_addr_mask | input | 1 | Address/bank output mask |
| lowpower | input | 1 | Low-power state |
| cke_in | input | 2 | Clock enable levels from the controller |
| dram_ma | output | 13 | Address pins |
| dram_ba | output | 2 | Bank-address pins |
| dram_ma_oe | output | 1 | Address/bank output enable |
| dram_cs_n | output | 4 | Chip selects, active low |
| dram_ras_n | output | 2 | RAS per DIMM |
| dram_cas_n | output | 2 | CAS per DIMM |
| dram_we_n | output | 2 | WE per DIMM |
| dram_ctl_oe | output | 2 | Control output enable per DIMM |
| dram_cke | output | 2 | Clock enables |
| dram_cke_oe | output | 2 | Clock enable output enables |

## Verification
The bench checks that a refresh is preceded by a precharge-all only while some bank of that rank is open. It opens banks on a neighbouring rank and closes banks with single-bank and all-bank precharges first, so a tracker that loses or mixes per-rank state would insert a spurious precharge-all or omit a needed one. It sends commands back to back with the gap both on and off. A design that ignored the gap would place two commands in adjacent cycles, and one that dropped the held request would lose the second command. The debug cycle is checked with and without a read's byte enables, which catches a design that splices enables into the wrong bits or after writes. The enables are checked under every mask code and during low-power command cycles, which catches a design that inverts the mask encoding or gates on the wrong DIMM.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PALL = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } dram_cmd_e;

  // RAS, CAS, WE levels for a command
  function automatic logic [2:0] rcw_code(dram_cmd_e c);
    case (c)
      CMD_ACT:           return 3'b011;
      CMD_RD:            return 3'b101;
      CMD_WR:            return 3'b100;
      CMD_PRE, CMD_PALL: return 3'b010;
      CMD_REF:           return 3'b001;
      CMD_MRS:           return 3'b000;
      default:           return 3'b111;
    endcase
  endfunction

  // commands that require every bank of the rank to be closed
  function automatic logic needs_closed(dram_cmd_e c);
    return (c == CMD_REF) || (c == CMD_MRS);
  endfunction

endpackage

// File: rtl/dcg_bank_track.sv
module dcg_bank_track
  import dcg_pkg::*;
#(
  parameter int RANKS = 4,
  parameter int BANKS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_fire,
  input  dram_cmd_e                 cmd,
  input  logic [$clog2(RANKS)-1:0]  rank,
  input  logic [$clog2(BANKS)-1:0]  bank,
  output logic                      rank_open
);

  logic [RANKS-1:0][BANKS-1:0] open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
    end else if (cmd_fire) begin
      case (cmd)
        CMD_ACT:  open_q[rank][bank] <= 1'b1;
        CMD_PRE:  open_q[rank][bank] <= 1'b0;
        CMD_PALL: open_q[rank]       <= '0;
        default:  ;
      endcase
    end
  end

  assign rank_open = |open_q[rank];

  // R12: precharge-all leaves the rank fully closed
  p_pall_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && (cmd == CMD_PALL) |=> (open_q[$past(rank)] == '0));

  // R12: activate marks the bank open
  p_act_opens_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && (cmd == CMD_ACT) |=> open_q[$past(rank)][$past(bank)]);

endmodule

// File: rtl/dcg_issue_ctl.sv
module dcg_issue_ctl
  import dcg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  dram_cmd_e req_cmd,
  input  logic      cfg_b2b_dis,
  input  logic      cfg_force_pre,
  input  logic      rank_open,
  input  logic      cmd_slot,
  output logic      req_ready,
  output logic      cmd_fire,
  output dram_cmd_e issue_cmd
);

  logic pre_done_q;
  logic gap_hold;
  logic want_pall;
  logic issue_fire;

  assign gap_hold   = cfg_b2b_dis && cmd_slot;
  assign want_pall  = req_valid && needs_closed(req_cmd) && !pre_done_q
                      && (rank_open || cfg_force_pre);
  assign issue_cmd  = want_pall ? CMD_PALL : req_cmd;
  assign issue_fire = req_valid && !gap_hold;
  assign cmd_fire   = issue_fire && (issue_cmd != CMD_NOP);
  assign req_ready  = !gap_hold && !want_pall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_done_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      pre_done_q <= 1'b0;
    end else if (issue_fire && want_pall) begin
      pre_done_q <= 1'b1;
    end
  end

  // R1: with the gap enabled, no command follows a command directly
  p_b2b_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_b2b_dis && cmd_fire |=> !cmd_fire);

  // R4: refresh/load-mode only reach the pins with the rank closed
  p_closed_before_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && needs_closed(issue_cmd) |-> !rank_open);

  // R10: an inserted precharge-all never consumes the request
  p_hold_on_insert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && (issue_cmd == CMD_PALL) && needs_closed(req_cmd) |-> !req_ready);

endmodule

// File: rtl/dcg_pin_drive.sv
module dcg_pin_drive
  import dcg_pkg::*;
#(
  parameter int RANKS  = 4,
  parameter int BANKS  = 4,
  parameter int ADDR_W = 13,
  parameter int BE_W   = 4,
  parameter int AP_BIT = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_fire,
  input  dram_cmd_e                 cmd,
  input  logic [$clog2(RANKS)-1:0]  rank,
  input  logic [$clog2(BANKS)-1:0]  bank,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BE_W-1:0]           be,
  input  logic                      be_vld,
  input  logic [ADDR_W-1:0]         dbg_data,
  input  logic                      cfg_dbg_en,
  input  logic                      cfg_rbe_en,
  input  logic                      cfg_tri_dis,
  input  logic [1:0]                cfg_cke_mask,
  input  logic [1:0]                cfg_ctl_mask,
  input  logic                      cfg_addr_mask,
  input  logic                      lowpower,
  input  logic [1:0]                cke_in,
  output logic                      cmd_slot,
  output logic [ADDR_W-1:0]         ma,
  output logic [$clog2(BANKS)-1:0]  ba,
  output logic                      ma_oe,
  output logic [RANKS-1:0]          cs_n,
  output logic [1:0]                ras_n,
  output logic [1:0]                cas_n,
  output logic [1:0]                we_n,
  output logic [1:0]                ctl_oe,
  output logic [1:0]                cke,
  output logic [1:0]                cke_oe
);

  localparam int NUM_DIMM = 2;
  localparam int RPD      = RANKS / NUM_DIMM;

  function automatic logic [ADDR_W-1:0] addr_for(dram_cmd_e c, logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    if (c == CMD_PALL) r[AP_BIT] = 1'b1;
    if (c == CMD_PRE)  r[AP_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] dbg_word(logic [ADDR_W-1:0] d,
                                                 logic [BE_W-1:0] b, logic use_b);
    return use_b ? {d[ADDR_W-1:BE_W], b} : d;
  endfunction

  logic                     cmd_slot_q, dbg_slot_q, dbg_go, tri_now;
  logic [BE_W-1:0]          last_be_q;
  logic                     last_use_q;
  logic [RANKS-1:0]         cs_next;
  logic [NUM_DIMM-1:0]      ras_next, cas_next, we_next;

  assign dbg_go = !cmd_fire && cfg_dbg_en && cmd_slot_q;

  always_comb begin
    logic [2:0] code;
    code = rcw_code(cmd);
    for (int r = 0; r < RANKS; r++) cs_next[r] = (int'(rank) != r);
    for (int d = 0; d < NUM_DIMM; d++) begin
      ras_next[d] = (int'(rank) / RPD == d) ? code[2] : 1'b1;
      cas_next[d] = (int'(rank) / RPD == d) ? code[1] : 1'b1;
      we_next[d]  = (int'(rank) / RPD == d) ? code[0] : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n       <= '1;
      ras_n      <= '1;
      cas_n      <= '1;
      we_n       <= '1;
      ma         <= '0;
      ba         <= '0;
      cmd_slot_q <= 1'b0;
      dbg_slot_q <= 1'b0;
      last_be_q  <= '0;
      last_use_q <= 1'b0;
    end else begin
      cmd_slot_q <= cmd_fire;
      dbg_slot_q <= dbg_go;
      if (cmd_fire) begin
        cs_n       <= cs_next;
        ras_n      <= ras_next;
        cas_n      <= cas_next;
        we_n       <= we_next;
        ma         <= addr_for(cmd, addr);
        ba         <= bank;
        last_be_q  <= be;
        last_use_q <= (cmd == CMD_RD) && be_vld;
      end else begin
        cs_n  <= '1;
        ras_n <= '1;
        cas_n <= '1;
        we_n  <= '1;
        ba    <= '0;
        ma    <= dbg_go ? dbg_word(dbg_data, last_be_q, cfg_rbe_en && last_use_q) : '0;
      end
    end
  end

  assign cmd_slot = cmd_slot_q;
  assign tri_now  = !cfg_tri_dis && (lowpower || !(cmd_slot_q || dbg_slot_q));
  assign ma_oe    = !cfg_addr_mask && !tri_now;
  assign cke      = cke_in;

  for (genvar d = 0; d < NUM_DIMM; d++) begin : g_ctl_oe
    assign ctl_oe[d] = !cfg_ctl_mask[d] && !tri_now;
  end
  for (genvar k = 0; k < 2; k++) begin : g_cke_oe
    assign cke_oe[k] = !cfg_cke_mask[k];
  end

  // R11: at most one chip select low
  p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R2: the debug cycle deselects every rank
  p_dbg_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_slot_q |-> (&cs_n) && (&ras_n) && (&cas_n) && (&we_n));

  // R9: idle pins released when tristating is allowed
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tri_dis && (&cs_n) && !dbg_slot_q |-> !ma_oe && (ctl_oe == 2'b00));

endmodule

// File: rtl/dram_cmd_gate.sv
module dram_cmd_gate
  import dcg_pkg::*;
#(
  parameter  int RANKS  = 4,
  parameter  int BANKS  = 4,
  parameter  int ADDR_W = 13,
  parameter  int BE_W   = 4,
  localparam int RK_W   = $clog2(RANKS),
  localparam int BA_W   = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [RK_W-1:0]   req_rank,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_be_vld,
  input  logic [ADDR_W-1:0] dbg_data,
  input  logic              cfg_b2b_dis,
  input  logic              cfg_dbg_en,
  input  logic              cfg_rbe_en,
  input  logic              cfg_force_pre,
  input  logic              cfg_tri_dis,
  input  logic [1:0]        cfg_cke_mask,
  input  logic [1:0]        cfg_ctl_mask,
  input  logic              cfg_addr_mask,
  input  logic              lowpower,
  input  logic [1:0]        cke_in,
  output logic [ADDR_W-1:0] dram_ma,
  output logic [BA_W-1:0]   dram_ba,
  output logic              dram_ma_oe,
  output logic [RANKS-1:0]  dram_cs_n,
  output logic [1:0]        dram_ras_n,
  output logic [1:0]        dram_cas_n,
  output logic [1:0]        dram_we_n,
  output logic [1:0]        dram_ctl_oe,
  output logic [1:0]        dram_cke,
  output logic [1:0]        dram_cke_oe
);

  dram_cmd_e req_cmd_e;
  dram_cmd_e issue_cmd;
  logic      cmd_fire;
  logic      rank_open;
  logic      cmd_slot;

  assign req_cmd_e = dram_cmd_e'(req_cmd);

  dcg_bank_track #(.RANKS(RANKS), .BANKS(BANKS)) i_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_fire),
    .cmd       (issue_cmd),
    .rank      (req_rank),
    .bank      (req_bank),
    .rank_open (rank_open)
  );

  dcg_issue_ctl i_issue (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_cmd       (req_cmd_e),
    .cfg_b2b_dis   (cfg_b2b_dis),
    .cfg_force_pre (cfg_force_pre),
    .rank_open     (rank_open),
    .cmd_slot      (cmd_slot),
    .req_ready     (req_ready),
    .cmd_fire      (cmd_fire),
    .issue_cmd     (issue_cmd)
  );

  dcg_pin_drive #(.RANKS(RANKS), .BANKS(BANKS), .ADDR_W(ADDR_W), .BE_W(BE_W)) i_pins (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_fire      (cmd_fire),
    .cmd           (issue_cmd),
    .rank          (req_rank),
    .bank          (req_bank),
    .addr          (req_addr),
    .be            (req_be),
    .be_vld        (req_be_vld),
    .dbg_data      (dbg_data),
    .cfg_dbg_en    (cfg_dbg_en),
    .cfg_rbe_en    (cfg_rbe_en),
    .cfg_tri_dis   (cfg_tri_dis),
    .cfg_cke_mask  (cfg_cke_mask),
    .cfg_ctl_mask  (cfg_ctl_mask),
    .cfg_addr_mask (cfg_addr_mask),
    .lowpower      (lowpower),
    .cke_in        (cke_in),
    .cmd_slot      (cmd_slot),
    .ma            (dram_ma),
    .ba            (dram_ba),
    .ma_oe         (dram_ma_oe),
    .cs_n          (dram_cs_n),
    .ras_n         (dram_ras_n),
    .cas_n         (dram_cas_n),
    .we_n          (dram_we_n),
    .ctl_oe        (dram_ctl_oe),
    .cke           (dram_cke),
    .cke_oe        (dram_cke_oe)
  );

endmodule

// File: tb/test_dram_cmd_gate.sv
module test_dram_cmd_gate;

  localparam int CLK_PERIOD = 10;
  localparam int NOPC = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PREA = 5, REF = 6, LMR = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cmd = '0;
  logic [1:0]  req_rank = '0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        req_be_vld = 1'b0;
  logic [12:0] dbg_data = '0;
  logic        cfg_b2b_dis = 1'b0, cfg_dbg_en = 1'b0, cfg_rbe_en = 1'b0;
  logic        cfg_force_pre = 1'b0, cfg_tri_dis = 1'b1, cfg_addr_mask = 1'b0;
  logic [1:0]  cfg_cke_mask = 2'b11, cfg_ctl_mask = 2'b00;
  logic        lowpower = 1'b0;
  logic [1:0]  cke_in = 2'b11;
  logic [12:0] dram_ma;
  logic [1:0]  dram_ba;
  logic        dram_ma_oe;
  logic [3:0]  dram_cs_n;
  logic [1:0]  dram_ras_n, dram_cas_n, dram_we_n, dram_ctl_oe, dram_cke, dram_cke_oe;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_cmd_gate i_dram_cmd_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_rank(req_rank), .req_bank(req_bank), .req_addr(req_addr),
    .req_be(req_be), .req_be_vld(req_be_vld), .dbg_data(dbg_data),
    .cfg_b2b_dis(cfg_b2b_dis), .cfg_dbg_en(cfg_dbg_en), .cfg_rbe_en(cfg_rbe_en),
    .cfg_force_pre(cfg_force_pre), .cfg_tri_dis(cfg_tri_dis), .cfg_cke_mask(cfg_cke_mask),
    .cfg_ctl_mask(cfg_ctl_mask), .cfg_addr_mask(cfg_addr_mask), .lowpower(lowpower),
    .cke_in(cke_in), .dram_ma(dram_ma), .dram_ba(dram_ba), .dram_ma_oe(dram_ma_oe),
    .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_ctl_oe(dram_ctl_oe), .dram_cke(dram_cke),
    .dram_cke_oe(dram_cke_oe)
  );

  // pin trace, one entry per cycle, sampled after the falling edge
  int   tr_cmd  [64];
  int   tr_rank [64];
  int   tr_ma   [64];
  int   tr_maoe [64];
  int   tr_cs   [64];
  int   tr_rcw0 [64];
  int   tr_rcw1 [64];
  int   tr_n = 0;
  bit   tr_on = 1'b0;

  always @(negedge clk) begin
    #2;
    if (tr_on && tr_n < 64) begin
      int r;
      int code;
      logic [2:0] rcw;
      r = -1;
      for (int i = 0; i < 4; i++) if (!dram_cs_n[i]) r = i;
      code = NOPC;
      if (r >= 0) begin
        rcw = (r < 2) ? {dram_ras_n[0], dram_cas_n[0], dram_we_n[0]}
                      : {dram_ras_n[1], dram_cas_n[1], dram_we_n[1]};
        case (rcw)
          3'b011: code = ACT;
          3'b101: code = RD;
          3'b100: code = WR;
          3'b010: code = dram_ma[10] ? PREA : PRE;
          3'b001: code = REF;
          3'b000: code = LMR;
          default: code = NOPC;
        endcase
      end
      tr_cmd[tr_n]  = code;
      tr_rank[tr_n] = r;
      tr_ma[tr_n]   = int'(dram_ma);
      tr_maoe[tr_n] = int'(dram_ma_oe);
      tr_cs[tr_n]   = int'(dram_cs_n);
      tr_rcw0[tr_n] = int'({dram_ras_n[0], dram_cas_n[0], dram_we_n[0]});
      tr_rcw1[tr_n] = int'({dram_ras_n[1], dram_cas_n[1], dram_we_n[1]});
      tr_n++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic chk_eq(string req, string what, int act, int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic trace_start();
    tr_n = 0;
    tr_on = 1'b1;
  endtask

  task automatic trace_stop();
    tr_on = 1'b0;
  endtask

  function automatic int first_cmd();
    for (int i = 0; i < tr_n; i++) if (tr_cmd[i] != NOPC) return i;
    return -1;
  endfunction

  task automatic push(int c, int rk, int bk, int ad, int be, bit bev);
    @(negedge clk);
    req_valid  = 1'b1;
    req_cmd    = c[2:0];
    req_rank   = rk[1:0];
    req_bank   = bk[1:0];
    req_addr   = ad[12:0];
    req_be     = be[3:0];
    req_be_vld = bev;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic go_idle(int n);
    @(negedge clk);
    req_valid  = 1'b0;
    req_cmd    = 3'd0;
    req_be_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // returns index of first command, failing once if none was seen
  function automatic int find_first(string req);
    int k;
    k = first_cmd();
    if (k < 0) begin
      checks++;
      errors++;
      $display("FAIL %s no command on pins: actual -1 expected >=0", req);
      k = 0;
    end
    return k;
  endfunction

  task automatic t_reset();
    #1;
    chk_eq("R13", "cs_n in reset", int'(dram_cs_n), 4'hF);
    chk_eq("R13", "ras_n in reset", int'(dram_ras_n), 2'b11);
    chk_eq("R13", "ma in reset", int'(dram_ma), 0);
    @(posedge rst_n);
    @(negedge clk);
    #1;
    chk_eq("R13", "ready after reset", int'(req_ready), 1);
    chk_eq("R6", "cke_oe with mask 11", int'(dram_cke_oe), 2'b00);
    chk_eq("R7", "ctl_oe unmasked", int'(dram_ctl_oe), 2'b11);
    chk_eq("R9", "ma_oe driven idle with tri_dis=1", int'(dram_ma_oe), 1);
  endtask

  task automatic t_encode();
    int k;
    trace_start();
    push(ACT, 2, 3, 13'h155, 0, 0);
    push(PRE, 2, 3, 13'h400, 0, 0);
    go_idle(3);
    trace_stop();
    k = find_first("R11");
    chk_eq("R11", "ACT on rank 2", tr_cmd[k], ACT);
    chk_eq("R11", "cs_n rank 2", tr_cs[k], 4'b1011);
    chk_eq("R11", "DIMM1 rcw", tr_rcw1[k], 3'b011);
    chk_eq("R11", "DIMM0 rcw idle", tr_rcw0[k], 3'b111);
    chk_eq("R11", "ACT address", tr_ma[k], 13'h155);
    chk_eq("R11", "PRE with A10 low", tr_cmd[k+1], PRE);
  endtask

  task automatic t_back_to_back();
    int k;
    trace_start();
    push(ACT, 0, 1, 13'h020, 0, 0);
    push(RD, 0, 1, 13'h008, 0, 0);
    push(WR, 0, 1, 13'h010, 0, 0);
    go_idle(3);
    trace_stop();
    k = find_first("R10");
    chk_eq("R10", "first ACT", tr_cmd[k], ACT);
    chk_eq("R1", "RD right after ACT, gap off", tr_cmd[k+1], RD);
    chk_eq("R10", "WR third in order", tr_cmd[k+2], WR);
    chk_eq("R10", "WR address kept", tr_ma[k+2], 13'h010);
  endtask

  task automatic t_gap();
    int k;
    cfg_b2b_dis = 1'b1;
    trace_start();
    push(RD, 0, 1, 13'h004, 0, 0);
    push(WR, 0, 1, 13'h00C, 0, 0);
    go_idle(4);
    trace_stop();
    cfg_b2b_dis = 1'b0;
    k = find_first("R1");
    chk_eq("R1", "RD first", tr_cmd[k], RD);
    chk_eq("R1", "empty cycle after RD", tr_cmd[k+1], NOPC);
    chk_eq("R2", "idle ma zero with debug off", tr_ma[k+1], 0);
    chk_eq("R1", "held WR issued late", tr_cmd[k+2], WR);
    chk_eq("R10", "WR address after stall", tr_ma[k+2], 13'h00C);
  endtask

  task automatic t_prea_insert();
    int k;
    trace_start();
    push(LMR, 0, 0, 13'h033, 0, 0);
    go_idle(3);
    trace_stop();
    k = find_first("R4");
    chk_eq("R4", "precharge-all inserted", tr_cmd[k], PREA);
    chk_eq("R4", "precharge-all rank", tr_rank[k], 0);
    chk_eq("R4", "LMR follows", tr_cmd[k+1], LMR);
    chk_eq("R10", "LMR address", tr_ma[k+1], 13'h033);
  endtask

  task automatic t_tracking();
    int k;
    trace_start();
    push(ACT, 0, 2, 13'h001, 0, 0);
    push(PRE, 0, 2, 13'h000, 0, 0);
    push(ACT, 1, 0, 13'h002, 0, 0);
    push(REF, 0, 0, 13'h000, 0, 0);
    push(PREA, 1, 0, 13'h000, 0, 0);
    push(REF, 1, 0, 13'h000, 0, 0);
    go_idle(3);
    trace_stop();
    k = find_first("R12");
    chk_eq("R12", "REF rank0 after PRE, no insert", tr_cmd[k+3], REF);
    chk_eq("R12", "REF rank0 rank", tr_rank[k+3], 0);
    chk_eq("R12", "explicit PREA rank1", tr_cmd[k+4], PREA);
    chk_eq("R12", "REF rank1 after PREA, no insert", tr_cmd[k+5], REF);
    chk_eq("R12", "nothing extra after", tr_cmd[k+6], NOPC);
  endtask

  task automatic t_force();
    int k;
    cfg_force_pre = 1'b1;
    trace_start();
    push(REF, 3, 0, 13'h000, 0, 0);
    go_idle(3);
    trace_stop();
    cfg_force_pre = 1'b0;
    k = find_first("R5");
    chk_eq("R5", "forced precharge-all", tr_cmd[k], PREA);
    chk_eq("R5", "forced precharge-all rank", tr_rank[k], 3);
    chk_eq("R5", "REF follows", tr_cmd[k+1], REF);
  endtask

  task automatic t_debug();
    int k;
    cfg_b2b_dis = 1'b1;
    cfg_dbg_en  = 1'b1;
    dbg_data    = 13'h1A5C;
    trace_start();
    push(ACT, 0, 0, 13'h0F0, 0, 0);
    go_idle(3);
    trace_stop();
    k = find_first("R2");
    chk_eq("R2", "ACT address", tr_ma[k], 13'h0F0);
    chk_eq("R2", "debug word after cmd", tr_ma[k+1], 13'h1A5C);
    chk_eq("R2", "all deselected in debug cycle", tr_cs[k+1], 4'hF);
    chk_eq("R2", "debug word once only", tr_ma[k+2], 0);
  endtask

  task automatic t_rbe();
    int k;
    cfg_rbe_en = 1'b1;
    trace_start();
    push(RD, 0, 0, 13'h000, 4'hA, 1'b1);
    go_idle(2);
    trace_stop();
    k = find_first("R3");
    chk_eq("R3", "byte enables spliced", tr_ma[k+1], 13'h1A5A);
    trace_start();
    push(RD, 0, 0, 13'h000, 4'h3, 1'b0);
    go_idle(2);
    trace_stop();
    k = find_first("R3");
    chk_eq("R3", "read without enables", tr_ma[k+1], 13'h1A5C);
    trace_start();
    push(WR, 0, 0, 13'h000, 4'h5, 1'b1);
    go_idle(2);
    trace_stop();
    k = find_first("R3");
    chk_eq("R3", "write leaves word", tr_ma[k+1], 13'h1A5C);
    cfg_rbe_en = 1'b0;
    trace_start();
    push(RD, 0, 0, 13'h000, 4'h6, 1'b1);
    go_idle(2);
    trace_stop();
    k = find_first("R3");
    chk_eq("R3", "splice off", tr_ma[k+1], 13'h1A5C);
    push(PRE, 0, 0, 13'h000, 0, 0);
    go_idle(2);
    cfg_dbg_en  = 1'b0;
    cfg_b2b_dis = 1'b0;
  endtask

  task automatic t_masks();
    @(negedge clk);
    cfg_cke_mask = 2'b00; #1;
    chk_eq("R6", "cke mask 00", int'(dram_cke_oe), 2'b11);
    cfg_cke_mask = 2'b01; #1;
    chk_eq("R6", "cke mask 01", int'(dram_cke_oe), 2'b10);
    cfg_cke_mask = 2'b10; #1;
    chk_eq("R6", "cke mask 10", int'(dram_cke_oe), 2'b01);
    chk_eq("R6", "cke level passes", int'(dram_cke), 2'b11);
    cfg_cke_mask = 2'b00;
    cfg_ctl_mask = 2'b10; #1;
    chk_eq("R7", "ctl mask DIMM1", int'(dram_ctl_oe), 2'b01);
    cfg_ctl_mask = 2'b01; #1;
    chk_eq("R7", "ctl mask DIMM0", int'(dram_ctl_oe), 2'b10);
    chk_eq("R8", "ma_oe before addr mask", int'(dram_ma_oe), 1);
    cfg_ctl_mask = 2'b00;
    cfg_addr_mask = 1'b1; #1;
    chk_eq("R8", "addr mask", int'(dram_ma_oe), 0);
    chk_eq("R8", "addr mask leaves ctl", int'(dram_ctl_oe), 2'b11);
    cfg_addr_mask = 1'b0;
  endtask

  task automatic t_tristate();
    int k;
    cfg_tri_dis = 1'b0;
    trace_start();
    push(ACT, 0, 0, 13'h011, 0, 0);
    go_idle(3);
    trace_stop();
    k = find_first("R9");
    chk_eq("R9", "driven in cmd cycle", tr_maoe[k], 1);
    chk_eq("R9", "released when idle", tr_maoe[k+1], 0);
    lowpower = 1'b1;
    trace_start();
    push(PRE, 0, 0, 13'h000, 0, 0);
    go_idle(3);
    trace_stop();
    k = find_first("R9");
    chk_eq("R9", "released in low power cmd cycle", tr_maoe[k], 0);
    #1;
    chk_eq("R9", "ctl released in low power", int'(dram_ctl_oe), 0);
    lowpower = 1'b0;
    cfg_tri_dis = 1'b1;
    #1;
    chk_eq("R9", "driven again with tri_dis", int'(dram_ma_oe), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    fork
      t_reset();
      begin #(CLK_PERIOD / 4); rst_n = 1'b1; end
    join
    repeat (2) @(negedge clk);
    t_encode();
    t_back_to_back();
    t_gap();
    t_prea_insert();
    t_tracking();
    t_force();
    t_debug();
    t_rbe();
    t_masks();
    t_tristate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule